// File: doc/BRIEF.md
# T1 Transmit Frame Timing Generator

This block produces all transmit-side timing for a 1.544 Mb/s T1 line. A bit counter steps through the 193 slots of a frame (one framing slot, then 24 channels of 8 bits each). A frame counter steps through a multiframe of either 12 frames (superframe mode) or 24 frames (extended superframe mode). From these two counters the block decodes a channel clock, a multiframe marker, a signaling-select level, a signaling-frame flag and a link-data demand clock. It also decodes the strobes that pick when payload, ABCD signaling and link bits are taken.

The counters free-run when both sync inputs stay low. A rising edge on the frame sync input forces the next cycle to be a framing slot and leaves the frame number as it was. A rising edge on the multiframe sync input forces the next cycle to be the framing slot of frame 1. All logic runs on the rising edge of one line-rate clock. The falling-edge sampling of a real line interface is replaced by one-cycle enables that the outputs carry. The merged serial stream leaves through a single register.

Top module: `t1_tx_timing`

## Requirements
- R1: A frame is 193 clock cycles. `fbit_time` is high only in the first cycle (the framing slot), and after reset the first cycle is the framing slot of frame 1.
- R2: With both sync inputs low the frame counter wraps after 12 frames when `esf_mode`=0 and after 24 frames when `esf_mode`=1. `mf_out` is high during the first half of the multiframe (frames 1-6, or 1-12) and low otherwise.
- R3: If `fsync_in` is sampled high at a clock edge after being low at the previous edge, the next cycle is a framing slot and the frame number is unchanged.
- R4: If `msync_in` is sampled high at an edge after being low at the previous edge, the next cycle is the framing slot of frame 1. This takes precedence over R3.
- R5: `chan_clk` is low in the framing slot. It is high for channel bits 1-4 and low for channel bits 5-8 of every channel, so it has 24 periods per frame.
- R6: `sig_sel` is high in frames 1-6 and 13-18 and low in frames 7-12 and 19-24, in either mode.
- R7: `sig_frame` is high for the whole of frames 6, 12, 18 and 24 (only 6 and 12 exist in superframe mode) and low in all other frames.
- R8: `abcd_take` is high in the 8th bit (LSB) of each channel in signaling frames while `sig_ins_en`=1. It is never high otherwise.
- R9: `link_clk` is high for the whole of odd frames (1, 3, ...) when `esf_mode`=1 and of even frames (2, 4, ...) when `esf_mode`=0. `link_take` is high in the framing slot of exactly those frames.
- R10: `ser_out` is registered and lags its slot by one cycle. It carries `link_in` for a `link_take` slot, 0 for any other framing slot, `abcd_in` for an `abcd_take` slot, and `ser_in` for all remaining slots. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esf_mode | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame superframe |
| fsync_in | input | 1 | Frame sync; rising edge realigns the bit counter |
| msync_in | input | 1 | Multiframe sync; rising edge realigns bit and frame counters |
| sig_ins_en | input | 1 | Enables ABCD signaling insertion |
| ser_in | input | 1 | Serial payload data |
| abcd_in | input | 1 | ABCD signaling bit |
| link_in | input | 1 | Link data bit for framing slots |
| fbit_time | output | 1 | High in the framing slot |
| chan_clk | output | 1 | Channel time-slot clock |
| mf_out | output | 1 | Multiframe marker, high in the first half |
| sig_sel | output | 1 | Signaling-select level |
| sig_frame | output | 1 | High during signaling frames |
| link_clk | output | 1 | Link-data demand clock |
| link_take | output | 1 | Link bit is taken in this slot |
| abcd_take | output | 1 | ABCD bit is taken in this slot |
| ser_out | output | 1 | Merged serial stream, one cycle late |

## Verification
A corrupted bit or frame counter shows at once, in the same cycle, as `fbit_time`, `chan_clk` or the frame-level outputs disagreeing with the slot a free counter would predict. A frame-count error shows no later than the next frame boundary, when `mf_out`, `sig_sel`, `sig_frame` or `link_clk` changes in the wrong frame. A mis-handled sync edge is visible in the cycle after the edge as a missing framing slot. A wrong source selection in the merge register shows on `ser_out` one cycle after the affected slot.

// File: rtl/t1tx_pkg.sv
package t1tx_pkg;
  parameter int CH_BITS  = 8;
  parameter int N_CH     = 24;
  parameter int SF_LEN   = 12;
  parameter int ESF_LEN  = 24;
  parameter int SIG_GAP  = 6;

  localparam int FRAME_SLOTS = 1 + N_CH * CH_BITS;
  localparam int BIT_W       = $clog2(FRAME_SLOTS);
  localparam int FRM_W       = $clog2(ESF_LEN);

  // last frame index of the multiframe for the selected mode
  function automatic int mf_last(input logic esf);
    return esf ? ESF_LEN - 1 : SF_LEN - 1;
  endfunction

  // position of a slot inside its channel, -1 for the framing slot
  function automatic int chan_pos(input int slot);
    if (slot == 0) return -1;
    return (slot - 1) % CH_BITS;
  endfunction

  function automatic logic chclk_level(input int slot);
    int p;
    p = chan_pos(slot);
    return (p >= 0) && (p < CH_BITS / 2);
  endfunction

  function automatic logic is_lsb(input int slot);
    return chan_pos(slot) == CH_BITS - 1;
  endfunction

  function automatic logic mf_high(input int frm, input logic esf);
    return frm < (mf_last(esf) + 1) / 2;
  endfunction

  function automatic logic sig_level(input int frm);
    return ((frm / SIG_GAP) % 2) == 0;
  endfunction

  function automatic logic is_sig_frame(input int frm);
    return (frm % SIG_GAP) == SIG_GAP - 1;
  endfunction

  // frame index 0 is frame 1: odd frames carry link in extended mode
  function automatic logic is_link_frame(input int frm, input logic esf);
    return esf ? ((frm % 2) == 0) : ((frm % 2) == 1);
  endfunction
endpackage

// File: rtl/t1tx_edge.sv
module t1tx_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_edge
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~q;
  end
endmodule

// File: rtl/t1tx_counter.sv
module t1tx_counter
  import t1tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             esf,
  input  logic             fsync_rise,
  input  logic             msync_rise,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [FRM_W-1:0] frame_cnt
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_SLOTS - 1);

  logic frame_end;
  logic mf_end;
  assign frame_end = (bit_cnt == LAST_BIT);
  assign mf_end    = (int'(frame_cnt) >= mf_last(esf));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      frame_cnt <= '0;
    end else if (msync_rise) begin
      bit_cnt   <= '0;
      frame_cnt <= '0;
    end else if (fsync_rise) begin
      bit_cnt   <= '0;
    end else if (frame_end) begin
      bit_cnt   <= '0;
      frame_cnt <= mf_end ? '0 : frame_cnt + 1'b1;
    end else begin
      bit_cnt   <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/t1tx_decode.sv
module t1tx_decode
  import t1tx_pkg::*;
(
  input  logic [BIT_W-1:0] bit_cnt,
  input  logic [FRM_W-1:0] frame_cnt,
  input  logic             esf,
  input  logic             sig_ins_en,
  output logic             fbit_time,
  output logic             chan_clk,
  output logic             mf_out,
  output logic             sig_sel,
  output logic             sig_frame,
  output logic             link_clk,
  output logic             link_take,
  output logic             abcd_take
);
  int slot;
  int frm;

  always_comb begin
    slot      = int'(bit_cnt);
    frm       = int'(frame_cnt);
    fbit_time = (slot == 0);
    chan_clk  = chclk_level(slot);
    mf_out    = mf_high(frm, esf);
    sig_sel   = sig_level(frm);
    sig_frame = is_sig_frame(frm);
    link_clk  = is_link_frame(frm, esf);
    link_take = fbit_time && link_clk;
    abcd_take = sig_ins_en && sig_frame && is_lsb(slot);
  end
endmodule

// File: rtl/t1_tx_timing.sv
module t1_tx_timing
  import t1tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic esf_mode,
  input  logic fsync_in,
  input  logic msync_in,
  input  logic sig_ins_en,
  input  logic ser_in,
  input  logic abcd_in,
  input  logic link_in,
  output logic fbit_time,
  output logic chan_clk,
  output logic mf_out,
  output logic sig_sel,
  output logic sig_frame,
  output logic link_clk,
  output logic link_take,
  output logic abcd_take,
  output logic ser_out
);
  logic [1:0]       rise;
  logic             fsync_rise;
  logic             msync_rise;
  logic [BIT_W-1:0] bit_cnt;
  logic [FRM_W-1:0] frame_cnt;
  logic             next_bit;

  t1tx_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({msync_in, fsync_in}),
    .rise (rise)
  );
  assign fsync_rise = rise[0];
  assign msync_rise = rise[1];

  t1tx_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .esf       (esf_mode),
    .fsync_rise(fsync_rise),
    .msync_rise(msync_rise),
    .bit_cnt   (bit_cnt),
    .frame_cnt (frame_cnt)
  );

  t1tx_decode u_dec (
    .bit_cnt   (bit_cnt),
    .frame_cnt (frame_cnt),
    .esf       (esf_mode),
    .sig_ins_en(sig_ins_en),
    .fbit_time (fbit_time),
    .chan_clk  (chan_clk),
    .mf_out    (mf_out),
    .sig_sel   (sig_sel),
    .sig_frame (sig_frame),
    .link_clk  (link_clk),
    .link_take (link_take),
    .abcd_take (abcd_take)
  );

  always_comb begin
    if (link_take)      next_bit = link_in;
    else if (fbit_time) next_bit = 1'b0;
    else if (abcd_take) next_bit = abcd_in;
    else                next_bit = ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_out <= 1'b0;
    else        ser_out <= next_bit;
  end
endmodule

// File: rtl/t1tx_chk.sv
module t1tx_chk
  import t1tx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             esf_mode,
  input logic             fsync_rise,
  input logic             msync_rise,
  input logic [BIT_W-1:0] bit_cnt,
  input logic [FRM_W-1:0] frame_cnt,
  input logic             fbit_time,
  input logic             chan_clk,
  input logic             sig_frame,
  input logic             abcd_take,
  input logic             link_take,
  input logic             link_in,
  input logic             ser_out
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_SLOTS - 1);

  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) < FRAME_SLOTS); // R1
  AST_MF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!msync_rise && !fsync_rise && bit_cnt == LAST_BIT && int'(frame_cnt) == mf_last(esf_mode))
    |=> (bit_cnt == '0 && frame_cnt == '0)); // R2
  AST_FSYNC_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_rise && !msync_rise) |=> (bit_cnt == '0 && frame_cnt == $past(frame_cnt))); // R3
  AST_MSYNC_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    msync_rise |=> (bit_cnt == '0 && frame_cnt == '0)); // R4
  AST_CHCLK_LOW_F: assert property (@(posedge clk) disable iff (!rst_n)
    fbit_time |-> !chan_clk); // R5
  AST_ABCD_IN_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    abcd_take |-> (sig_frame && !fbit_time)); // R8
  AST_LINK_AT_F: assert property (@(posedge clk) disable iff (!rst_n)
    link_take |-> fbit_time); // R9
  AST_LINK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    link_take |=> ser_out == $past(link_in)); // R10
endmodule

bind t1_tx_timing t1tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .esf_mode  (esf_mode),
  .fsync_rise(fsync_rise),
  .msync_rise(msync_rise),
  .bit_cnt   (bit_cnt),
  .frame_cnt (frame_cnt),
  .fbit_time (fbit_time),
  .chan_clk  (chan_clk),
  .sig_frame (sig_frame),
  .abcd_take (abcd_take),
  .link_take (link_take),
  .link_in   (link_in),
  .ser_out   (ser_out)
);

// File: tb/tb_t1_tx_timing.sv
module tb_t1_tx_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esf_mode = 1'b0, fsync_in = 1'b0, msync_in = 1'b0, sig_ins_en = 1'b0;
  logic ser_in = 1'b0, abcd_in = 1'b0, link_in = 1'b0;
  logic fbit_time, chan_clk, mf_out, sig_sel, sig_frame, link_clk;
  logic link_take, abcd_take, ser_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  t1_tx_timing dut (.*);

  // behavioural reference: slot and frame kept as plain integers
  int m_slot, m_frm, m_pf, m_pm;
  logic m_ser;

  function automatic int mf_len(input logic e);
    return e ? 24 : 12;
  endfunction

  function automatic logic e_link(input int f, input logic e);
    int num;
    num = f + 1;
    return e ? (num % 2 == 1) : (num % 2 == 0);
  endfunction

  function automatic logic e_abcd(input int s, input int f, input logic en);
    return en && ((f + 1) % 6 == 0) && (s != 0) && (s % 8 == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot = 0; m_frm = 0; m_pf = 0; m_pm = 0; m_ser = 1'b0;
    end else begin
      if (m_slot == 0 && e_link(m_frm, esf_mode)) m_ser = link_in;
      else if (m_slot == 0)                        m_ser = 1'b0;
      else if (e_abcd(m_slot, m_frm, sig_ins_en))  m_ser = abcd_in;
      else                                         m_ser = ser_in;
      if (msync_in && m_pm == 0) begin
        m_slot = 0; m_frm = 0;
      end else if (fsync_in && m_pf == 0) begin
        m_slot = 0;
      end else begin
        m_slot = m_slot + 1;
        if (m_slot == 193) begin
          m_slot = 0;
          m_frm = (m_frm + 1) % mf_len(esf_mode);
        end
      end
      m_pf = int'(fsync_in);
      m_pm = int'(msync_in);
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s slot=%0d frame=%0d actual=%b expected=%b",
               req, nm, m_slot, m_frm + 1, act, exp);
    end
  endtask

  task automatic compare_all();
    int pos;
    pos = (m_slot - 1) % 8;
    chk("R1", "fbit_time", fbit_time, m_slot == 0);
    chk("R5", "chan_clk", chan_clk, (m_slot != 0) && (pos < 4));
    chk("R2", "mf_out", mf_out, m_frm < mf_len(esf_mode) / 2);
    chk("R6", "sig_sel", sig_sel, ((m_frm + 1) <= 6) || ((m_frm + 1) >= 13 && (m_frm + 1) <= 18));
    chk("R7", "sig_frame", sig_frame, (m_frm + 1) % 6 == 0);
    chk("R9", "link_clk", link_clk, e_link(m_frm, esf_mode));
    chk("R9", "link_take", link_take, (m_slot == 0) && e_link(m_frm, esf_mode));
    chk("R8", "abcd_take", abcd_take, e_abcd(m_slot, m_frm, sig_ins_en));
    chk("R10", "ser_out", ser_out, m_ser);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      ser_in  = 1'($urandom);
      abcd_in = 1'($urandom);
      link_in = 1'($urandom);
    end
  endtask

  task automatic pulse_f();
    fsync_in = 1'b1; step(1); fsync_in = 1'b0;
  endtask

  task automatic pulse_m();
    msync_in = 1'b1; step(1); msync_in = 1'b0;
  endtask

  task automatic restart(input logic e, input logic en);
    @(negedge clk);
    rst_n = 1'b0; esf_mode = e; sig_ins_en = en;
    step(3);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state (R1, R10)
    step(4);
    rst_n = 1'b1;
    // superframe free run, two multiframes (R1, R2, R5-R10)
    sig_ins_en = 1'b1;
    step(2 * 12 * 193 + 20);
    // mid-multiframe frame sync then multiframe sync (R3, R4)
    step(700);
    pulse_f();
    step(1500);
    pulse_m();
    step(2 * 12 * 193);
    // both syncs together: multiframe wins (R4)
    step(333);
    fsync_in = 1'b1; msync_in = 1'b1; step(1); fsync_in = 1'b0; msync_in = 1'b0;
    step(400);
    // extended superframe, two multiframes (R2, R6, R7, R9)
    restart(1'b1, 1'b1);
    step(2 * 24 * 193 + 20);
    // resync in extended mode, then periodic frame sync (R3, R4)
    step(1000);
    pulse_m();
    step(500);
    pulse_f();
    for (int k = 0; k < 8; k++) begin
      step(192);
      pulse_f();
    end
    // insertion disabled: no ABCD strobes (R8)
    restart(1'b1, 1'b0);
    step(24 * 193 + 10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule